// File: doc/BRIEF.md
# Adaptive Transmit Threshold Controller

This block decides how much of a frame must be queued in the transmit FIFO before the transmitter is allowed to start sending it. It holds a two-bit threshold code and a separate store-and-forward flag. Software loads the starting setting through a one-cycle write port. The transmitter reports an underflow as a one-cycle strobe. The controller then drops its start-transmit enable and waits for the transmitter to confirm that it has stopped. It then moves the setting one rung up a fixed ladder, pulses a clear for the pending stopped indication, and re-enables transmission.

The ladder is 128, 256, 512 and then 1024 bytes. After that the setting becomes full-frame store-and-forward, and it stays there. The FIFO, the framing logic and the DMA engine lie outside the block. All pins are plain control and status signals that are sampled on the rising clock edge. None of them is a data stream, so the block has no back-pressure.

Top module: `tx_thresh_ctrl`

## Requirements
- R1: After reset, the threshold code is 2'b00, store-and-forward is off, the run flag is off, tx_start_en is 0, stop_clr is 0 and the underflow count is 0.
- R2: A cycle with cfg_wr_en high loads the code, the store-and-forward flag and the run flag. When the loaded run flag is 1 and no recovery is in progress, tx_start_en is high from the next cycle on.
- R3: thresh_bytes equals 128 shifted left by the code: 2'b00 gives 128, 2'b01 gives 256, 2'b10 gives 512 and 2'b11 gives 1024.
- R4: An underflow strobe in a cycle where tx_start_en is high drops tx_start_en in the next cycle. It stays low until the recovery completes.
- R5: On the stopped acknowledgement that closes a recovery, the code steps up one rung: 00 to 01, 01 to 10, 10 to 11.
- R6: A recovery that starts with code 2'b11 and store-and-forward off sets store_fwd and leaves the code at 2'b11.
- R7: A recovery that starts with store_fwd set leaves the code and the flag unchanged.
- R8: The cycle after the closing acknowledgement has stop_clr high for exactly one cycle while tx_start_en is still low. tx_start_en returns high in the cycle after that.
- R9: While the controller waits for the acknowledgement, the code and the flag do not change unless software writes them.
- R10: The underflow count, CNT_W bits wide with a default of 16, goes up by one on every underflow strobe, whatever the state, and wraps at its maximum.
- R11: An underflow while tx_start_en is low, and an acknowledgement outside a recovery, change neither the setting nor tx_start_en, and they raise no stop_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | One-cycle write of the starting setting |
| cfg_code | input | 2 | Threshold code to load |
| cfg_sf | input | 1 | Store-and-forward flag to load |
| cfg_run | input | 1 | Allows transmission when 1 |
| underflow | input | 1 | Transmit underflow strobe |
| tx_stopped_ack | input | 1 | Transmitter confirms it has stopped |
| tx_start_en | output | 1 | Start-transmit enable |
| thresh_code | output | 2 | Current threshold code |
| thresh_bytes | output | 11 | Current threshold in bytes |
| store_fwd | output | 1 | Store-and-forward mode, which overrides the threshold |
| stop_clr | output | 1 | Clears the pending stopped indication |
| underflow_cnt | output | 16 | Count of underflow strobes |

## Verification
A sequencer stuck outside its run state shows up at once as tx_start_en held low after the acknowledgement. A missing or repeated stop_clr pulse is visible one cycle after the acknowledgement. A wrong ladder step shows on thresh_code, thresh_bytes or store_fwd in the same cycle that stop_clr rises. An update applied too early shows while the enable is still low, before any acknowledgement has arrived. A counter fault shows on the cycle after any strobe.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_RUN   = 2'd0,
    TT_STOP  = 2'd1,
    TT_CLEAR = 2'd2
  } tt_state_e;

  typedef struct packed {
    logic [1:0] code;
    logic       sf;
  } tt_setting_t;
endpackage

// File: rtl/tt_ladder.sv
module tt_ladder
  import tt_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  tt_setting_t cur,
  output tt_setting_t nxt
);
  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  always_comb begin
    nxt = cur;
    if (!cur.sf) begin
      if (cur.code == TOP_CODE) nxt.sf = 1'b1;
      else                      nxt.code = cur.code + 1'b1;
    end
  end
endmodule

// File: rtl/tt_seq.sv
module tt_seq
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic underflow,
  input  logic ack,
  output logic start_en,
  output logic upd,
  output logic clr
);
  tt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TT_RUN:   if (run && underflow) state_d = TT_STOP;
      TT_STOP:  if (ack)              state_d = TT_CLEAR;
      TT_CLEAR:                       state_d = TT_RUN;
      default:                        state_d = TT_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TT_RUN;
    else        state_q <= state_d;
  end

  assign start_en = run && (state_q == TT_RUN);
  assign upd      = (state_q == TT_STOP) && ack;
  assign clr      = (state_q == TT_CLEAR);
endmodule

// File: rtl/tt_ucount.sv
module tt_ucount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/tx_thresh_ctrl.sv
module tx_thresh_ctrl
  import tt_pkg::*;
#(
  parameter int BASE_BYTES = 128,
  parameter int CNT_W      = 16,
  localparam int CODE_W    = 2,
  localparam int BYTES_W   = $clog2(BASE_BYTES << ((1 << CODE_W) - 1)) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [CODE_W-1:0]  cfg_code,
  input  logic               cfg_sf,
  input  logic               cfg_run,
  input  logic               underflow,
  input  logic               tx_stopped_ack,
  output logic               tx_start_en,
  output logic [CODE_W-1:0]  thresh_code,
  output logic [BYTES_W-1:0] thresh_bytes,
  output logic               store_fwd,
  output logic               stop_clr,
  output logic [CNT_W-1:0]   underflow_cnt
);
  tt_setting_t set_q, set_up;
  logic        run_q;
  logic        upd;

  tt_ladder #(.CODE_W(CODE_W)) ladder_i (.cur(set_q), .nxt(set_up));

  tt_seq seq_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .underflow(underflow),
    .ack(tx_stopped_ack), .start_en(tx_start_en), .upd(upd), .clr(stop_clr)
  );

  tt_ucount #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(underflow), .count(underflow_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      run_q <= 1'b0;
    end else if (cfg_wr_en) begin
      set_q.code <= cfg_code;
      set_q.sf   <= cfg_sf;
      run_q      <= cfg_run;
    end else if (upd) begin
      set_q <= set_up;
    end
  end

  localparam logic [BYTES_W-1:0] BASE_V = BYTES_W'(BASE_BYTES);

  assign thresh_code  = set_q.code;
  assign store_fwd    = set_q.sf;
  assign thresh_bytes = BASE_V << set_q.code;
endmodule

// File: rtl/tx_thresh_ctrl_chk.sv
module tx_thresh_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic             underflow,
  input logic             tx_stopped_ack,
  input logic             tx_start_en,
  input logic [1:0]       thresh_code,
  input logic             store_fwd,
  input logic             stop_clr,
  input logic [CNT_W-1:0] underflow_cnt
);
  assert_drop_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_en && underflow && !cfg_wr_en) |=> !tx_start_en);

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |=> !stop_clr);

  assert_clr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |-> !tx_start_en);

  assert_hold_setting_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && !tx_stopped_ack) |=> ($stable(thresh_code) && $stable(store_fwd)));

  assert_sf_from_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && !store_fwd) ##1 store_fwd |-> thresh_code == 2'b11);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow_cnt == $past(underflow_cnt) + 1'b1);
endmodule

bind tx_thresh_ctrl tx_thresh_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .underflow(underflow),
  .tx_stopped_ack(tx_stopped_ack), .tx_start_en(tx_start_en),
  .thresh_code(thresh_code), .store_fwd(store_fwd), .stop_clr(stop_clr),
  .underflow_cnt(underflow_cnt)
);

// File: tb/tx_thresh_ctrl_tb_top.sv
module tx_thresh_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_code = '0;
  logic        cfg_sf = 1'b0;
  logic        cfg_run = 1'b0;
  logic        underflow = 1'b0;
  logic        tx_stopped_ack = 1'b0;
  logic        tx_start_en;
  logic [1:0]  thresh_code;
  logic [10:0] thresh_bytes;
  logic        store_fwd;
  logic        stop_clr;
  logic [15:0] underflow_cnt;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_cnt = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_thresh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_code(cfg_code),
    .cfg_sf(cfg_sf), .cfg_run(cfg_run), .underflow(underflow),
    .tx_stopped_ack(tx_stopped_ack), .tx_start_en(tx_start_en),
    .thresh_code(thresh_code), .thresh_bytes(thresh_bytes), .store_fwd(store_fwd),
    .stop_clr(stop_clr), .underflow_cnt(underflow_cnt)
  );

  // Each entry: start code, start sf, expected code, expected sf after one recovery
  localparam logic [5:0] VEC [5] = '{
    {2'b00, 1'b0, 2'b01, 1'b0},
    {2'b01, 1'b0, 2'b10, 1'b0},
    {2'b10, 1'b0, 2'b11, 1'b0},
    {2'b11, 1'b0, 2'b11, 1'b1},
    {2'b01, 1'b1, 2'b01, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] c, input logic s, input logic r);
    cfg_wr_en = 1'b1; cfg_code = c; cfg_sf = s; cfg_run = r;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_uf();
    underflow = 1'b1;
    step();
    underflow = 1'b0;
    exp_cnt++;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 code", thresh_code, 2'b00);
    chk("R1 sf", store_fwd, 1'b0);
    chk("R1 en", tx_start_en, 1'b0);
    chk("R1 clr", stop_clr, 1'b0);
    chk("R1 cnt", underflow_cnt, 16'd0);
    rst_n = 1'b1;
    step();

    // R11: underflow with enable low is counted but starts no recovery
    pulse_uf();
    chk("R11 en", tx_start_en, 1'b0);
    chk("R10 cnt idle", underflow_cnt, exp_cnt);
    tx_stopped_ack = 1'b1; step(); tx_stopped_ack = 1'b0;
    chk("R11 clr", stop_clr, 1'b0);
    chk("R11 code", thresh_code, 2'b00);

    for (int i = 0; i < 5; i++) begin
      logic [1:0] c0, c1;
      logic s0, s1;
      {c0, s0, c1, s1} = VEC[i];
      write_cfg(c0, s0, 1'b1);
      chk("R2 en", tx_start_en, 1'b1);
      chk("R3 bytes", thresh_bytes, 32'(128) << c0);
      pulse_uf();
      chk("R4 en low", tx_start_en, 1'b0);
      chk("R10 cnt", underflow_cnt, exp_cnt);
      step();
      chk("R9 code held", thresh_code, c0);
      chk("R9 sf held", store_fwd, s0);
      chk("R4 still low", tx_start_en, 1'b0);
      tx_stopped_ack = 1'b1; step(); tx_stopped_ack = 1'b0;
      chk("R8 clr", stop_clr, 1'b1);
      chk("R8 en low", tx_start_en, 1'b0);
      chk("R5 R6 R7 code", thresh_code, c1);
      chk("R6 R7 sf", store_fwd, s1);
      step();
      chk("R8 clr end", stop_clr, 1'b0);
      chk("R8 en back", tx_start_en, 1'b1);
    end

    // R11: underflow during a recovery is counted only
    write_cfg(2'b00, 1'b0, 1'b1);
    pulse_uf();
    pulse_uf();
    chk("R10 cnt busy", underflow_cnt, exp_cnt);
    tx_stopped_ack = 1'b1; step(); tx_stopped_ack = 1'b0;
    chk("R5 single step", thresh_code, 2'b01);
    step();
    chk("R11 en", tx_start_en, 1'b1);
    // R11: acknowledgement while running does nothing
    tx_stopped_ack = 1'b1; step(); tx_stopped_ack = 1'b0;
    chk("R11 clr idle", stop_clr, 1'b0);
    chk("R11 code idle", thresh_code, 2'b01);
    chk("R11 en idle", tx_start_en, 1'b1);
    chk("R3 bytes 256", thresh_bytes, 11'd256);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule